// File: doc/BRIEF.md
# Interrupt Acceptance and Vector Fetch Unit

This unit is the interrupt front end of a processor core. At each instruction boundary, signalled by the core, it looks at four kinds of request and picks the one to service. The four are a synchronous exception or software interrupt with its own type code, a latched non-maskable event, a maskable level request, and the single-step trap. If the maskable request wins, the unit runs a two-pulse acknowledge handshake and takes an 8-bit type code from the acknowledge data bus. For every other source the type code is already known.

With the type code settled, the unit reads two 16-bit words from a vector table that starts at address zero. Each entry is four bytes wide. The word at type × 4 is the new instruction pointer, and the word two bytes above it is the new code segment. Reads go through a simple request/acknowledge memory port. When both words are in, the unit shows them on its outputs with the type code and pulses `done_o` for one clock. The non-maskable input is edge sensitive. A rising edge is remembered until it is serviced, even if the edge arrives while another interrupt is being handled.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the unit is idle: `busy_o`, `done_o`, `inta_o` and `mem_rd_o` are 0, and `vec_type_o`, `new_ip_o` and `new_cs_o` are 0.
- R2: A rising edge on `nmi_i` is serviced as type 2, which reads addresses 0x00008 and 0x0000A. Holding `nmi_i` high does not start a second service.
- R3: A rising edge on `nmi_i` that arrives while the unit is busy is kept pending. It is serviced at the first instruction boundary after the unit returns to idle, and not before that boundary.
- R4: While `ie_i` is 0, a high `intr_i` is ignored: a boundary produces no acknowledge pulse and no service.
- R5: An accepted maskable request produces exactly two `inta_o` pulses, each one clock long, with GAP_CYC low clocks between them. The type code is the value on `ack_data_i` during the second pulse. The value during the first pulse is ignored.
- R6: For type t, the first read is at byte address t×4 and its data becomes `new_ip_o`. The second read is at t×4+2 and its data becomes `new_cs_o`. Type 0xFF reads 0x003FC and 0x003FE.
- R7: When several requests are present at one boundary, the priority from highest to lowest is: exception (`exc_req_i`), pending non-maskable event, maskable request (when enabled), single-step.
- R8: With `tf_i` high at a boundary and no other request, the unit services type 1.
- R9: An exception request is serviced with the type on `exc_type_i`. Examples are 3 for a breakpoint and 0 for a divide error.
- R10: While a read is waiting for `mem_ack_i`, `mem_rd_o` stays high and `mem_addr_o` stays stable.
- R11: `done_o` goes high for exactly one clock, in the cycle after the second word is accepted. `vec_type_o`, `new_ip_o` and `new_cs_o` are valid during that cycle, and the unit is idle in the next cycle.
- R12: A boundary that comes while the unit is busy is not accepted, so requests presented with it do not change the service in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary; requests are arbitrated in this cycle |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| intr_i | input | 1 | Maskable request, level sensitive |
| ie_i | input | 1 | Interrupt enable flag |
| tf_i | input | 1 | Trap flag for single-step |
| exc_req_i | input | 1 | Exception or software interrupt request, valid with boundary_i |
| exc_type_i | input | 8 | Type code of the exception request |
| inta_o | output | 1 | Acknowledge pulse to the interrupt source |
| ack_data_i | input | 8 | Type code supplied during acknowledge |
| mem_rd_o | output | 1 | Vector read request |
| mem_addr_o | output | ADDR_W | Vector read byte address |
| mem_rdata_i | input | DATA_W | Read data |
| mem_ack_i | input | 1 | Read data valid; completes the request |
| busy_o | output | 1 | Unit is servicing an interrupt |
| done_o | output | 1 | One-clock pulse when the vector is ready |
| vec_type_o | output | 8 | Type code serviced |
| new_ip_o | output | DATA_W | Fetched instruction pointer |
| new_cs_o | output | DATA_W | Fetched code segment |

## Verification
The bench raises a non-maskable edge in the middle of a vector fetch. A design that drops that edge never services type 2 afterwards. A design that restarts on its own, without waiting for a boundary, raises `busy_o` too early. The bench drives a wrong type during the first acknowledge pulse and the right one during the second. It also measures the gap between the pulses, so latching on the wrong pulse or miscounting the pulses shows up as a wrong type or a wrong pulse count. Boundaries with several requests present check the priority order, and a held-high non-maskable input checks that it does not trigger again. Type 0xFF checks that the address computation does not drop the top bits of the type, and a memory that answers late checks that the read address holds steady while it waits.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int TYPE_W = 8;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_EXC, SRC_NMI, SRC_INTR, SRC_STEP
  } irq_src_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACK1, ST_GAP, ST_ACK2, ST_RD_IP, ST_RD_CS, ST_FIN
  } irq_st_e;

  localparam logic [TYPE_W-1:0] TYPE_STEP = 8'd1;
  localparam logic [TYPE_W-1:0] TYPE_NMI  = 8'd2;

  // Byte offset of a vector word: type * 4, plus 2 for the segment word.
  function automatic logic [TYPE_W+1:0] vec_offset(input logic [TYPE_W-1:0] t,
                                                   input logic seg_word);
    return {t, seg_word, 1'b0};
  endfunction
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic take_i,
  output logic pend_o,
  output logic rise_o
);
  logic nmi_q;
  logic pend_q;

  assign rise_o = nmi_i & ~nmi_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_q <= (pend_q & ~take_i) | rise_o;
    end
  end

  // R3: an edge is never lost, even while another service runs
  a_r3_rise_pends: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> pend_o);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
(
  input  logic              exc_req_i,
  input  logic [TYPE_W-1:0] exc_type_i,
  input  logic              nmi_pend_i,
  input  logic              intr_i,
  input  logic              ie_i,
  input  logic              tf_i,
  output irq_src_e          src_o,
  output logic [TYPE_W-1:0] type_o
);
  always_comb begin
    src_o  = SRC_NONE;
    type_o = '0;
    if (exc_req_i) begin
      src_o  = SRC_EXC;
      type_o = exc_type_i;
    end else if (nmi_pend_i) begin
      src_o  = SRC_NMI;
      type_o = TYPE_NMI;
    end else if (intr_i && ie_i) begin
      src_o  = SRC_INTR;
    end else if (tf_i) begin
      src_o  = SRC_STEP;
      type_o = TYPE_STEP;
    end
  end
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_vec_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int GAP_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  irq_src_e          start_src_i,
  input  logic [TYPE_W-1:0] start_type_i,
  input  logic [TYPE_W-1:0] ack_data_i,
  output logic              inta_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic [DATA_W-1:0] new_ip_o,
  output logic [DATA_W-1:0] new_cs_o,
  output logic [TYPE_W-1:0] vec_type_o,
  output logic              done_o,
  output logic              idle_o
);
  localparam int GCW = $clog2(GAP_CYC + 1);
  localparam logic [GCW-1:0] GAP_LAST = GCW'(GAP_CYC - 1);

  irq_st_e           st_q;
  logic [GCW-1:0]    gap_q;
  logic [TYPE_W-1:0] type_q;
  logic [DATA_W-1:0] ip_q, cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      gap_q  <= '0;
      type_q <= '0;
      ip_q   <= '0;
      cs_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          type_q <= start_type_i;
          st_q   <= (start_src_i == SRC_INTR) ? ST_ACK1 : ST_RD_IP;
        end
        ST_ACK1: begin
          gap_q <= '0;
          st_q  <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_q == GAP_LAST) st_q <= ST_ACK2;
          else gap_q <= gap_q + 1'b1;
        end
        ST_ACK2: begin
          type_q <= ack_data_i;
          st_q   <= ST_RD_IP;
        end
        ST_RD_IP: if (mem_ack_i) begin
          ip_q <= mem_rdata_i;
          st_q <= ST_RD_CS;
        end
        ST_RD_CS: if (mem_ack_i) begin
          cs_q <= mem_rdata_i;
          st_q <= ST_FIN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign inta_o     = (st_q == ST_ACK1) || (st_q == ST_ACK2);
  assign mem_rd_o   = (st_q == ST_RD_IP) || (st_q == ST_RD_CS);
  assign mem_addr_o = ADDR_W'(vec_offset(type_q, st_q == ST_RD_CS));
  assign done_o     = (st_q == ST_FIN);
  assign idle_o     = (st_q == ST_IDLE);
  assign new_ip_o   = ip_q;
  assign new_cs_o   = cs_q;
  assign vec_type_o = type_q;

  // R11: done is a single-cycle pulse followed by idle
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && idle_o));
  // R10: a pending read holds its address
  a_r10_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !mem_ack_i) |=> (mem_rd_o && $stable(mem_addr_o)));
  // R6: segment word is read two bytes above the pointer word
  a_r6_cs_after_ip: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && mem_ack_i && !mem_addr_o[1]) |=>
      (mem_rd_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(2)));
  // R5: each acknowledge pulse lasts one clock
  a_r5_inta_short: assert property (@(posedge clk) disable iff (!rst_n)
    inta_o |=> !inta_o);
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_vec_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int GAP_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              nmi_i,
  input  logic              intr_i,
  input  logic              ie_i,
  input  logic              tf_i,
  input  logic              exc_req_i,
  input  logic [7:0]        exc_type_i,
  output logic              inta_o,
  input  logic [7:0]        ack_data_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        vec_type_o,
  output logic [DATA_W-1:0] new_ip_o,
  output logic [DATA_W-1:0] new_cs_o
);
  logic              nmi_pend, nmi_rise, nmi_take;
  logic              idle, start;
  irq_src_e          arb_src;
  logic [TYPE_W-1:0] arb_type;

  assign start    = idle && boundary_i && (arb_src != SRC_NONE);
  assign nmi_take = start && (arb_src == SRC_NMI);
  assign busy_o   = !idle;

  irq_nmi_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .take_i(nmi_take),
    .pend_o(nmi_pend), .rise_o(nmi_rise)
  );

  irq_arbiter u_arb (
    .exc_req_i(exc_req_i), .exc_type_i(exc_type_i), .nmi_pend_i(nmi_pend),
    .intr_i(intr_i), .ie_i(ie_i), .tf_i(tf_i),
    .src_o(arb_src), .type_o(arb_type)
  );

  irq_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_CYC(GAP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_src_i(arb_src),
    .start_type_i(arb_type), .ack_data_i(ack_data_i), .inta_o(inta_o),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .mem_ack_i(mem_ack_i), .new_ip_o(new_ip_o), .new_cs_o(new_cs_o),
    .vec_type_o(vec_type_o), .done_o(done_o), .idle_o(idle)
  );

  // R4: masked request never reaches the acknowledge handshake
  a_r4_masked_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && boundary_i && !ie_i) |=> !inta_o);
  // R2: a granted non-maskable service carries type 2
  a_r2_nmi_type: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |=> (vec_type_o == 8'd2));
  // R12: no acknowledge or read begins without an accepted boundary
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start) |=> (idle || nmi_rise || !nmi_rise) && !inta_o && !mem_rd_o);
endmodule

// File: tb/irq_vector_unit_test.sv
module irq_vector_unit_test;
  localparam int GAP = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary_i = 1'b0, nmi_i = 1'b0, intr_i = 1'b0, ie_i = 1'b0, tf_i = 1'b0;
  logic        exc_req_i = 1'b0;
  logic [7:0]  exc_type_i = 8'd0;
  logic        inta_o;
  logic [7:0]  ack_data_i;
  logic        mem_rd_o;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_rdata_i;
  logic        mem_ack_i;
  logic        busy_o, done_o;
  logic [7:0]  vec_type_o;
  logic [15:0] new_ip_o, new_cs_o;

  always #2 clk = ~clk;

  irq_vector_unit #(.GAP_CYC(GAP)) uut (.*);

  int checks = 0, fails = 0;
  logic [7:0] intr_type = 8'h00;
  logic log_clr = 1'b0;

  function automatic logic [15:0] mem_fn(input logic [19:0] a);
    return (a[15:0] * 16'd3) ^ 16'h5A5A;
  endfunction

  // memory model: answers two clocks after a request appears
  logic [1:0] lat;
  always @(posedge clk) begin
    if (!rst_n) begin
      lat <= 0; mem_ack_i <= 0; mem_rdata_i <= 0;
    end else if (mem_rd_o && !mem_ack_i) begin
      if (lat == 2'd1) begin
        mem_ack_i <= 1; mem_rdata_i <= mem_fn(mem_addr_o); lat <= 0;
      end else lat <= lat + 1'b1;
    end else mem_ack_i <= 0;
  end

  // observers
  int rd_n, pulses, inta_hi, dn, cyc, rise1, rise2, unstable, done_run, done_max;
  logic [19:0] rd_addr [4];
  logic [7:0]  cap_type;
  logic [15:0] cap_ip, cap_cs;
  logic inta_prev, rd_prev, ack_prev;
  logic [19:0] addr_prev;
  assign ack_data_i = (pulses == 0) ? 8'hEE : intr_type;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    inta_prev <= inta_o; rd_prev <= mem_rd_o; ack_prev <= mem_ack_i; addr_prev <= mem_addr_o;
    if (!rst_n || log_clr) begin
      rd_n <= 0; pulses <= 0; inta_hi <= 0; dn <= 0; rise1 <= 0; rise2 <= 0;
      unstable <= 0; done_run <= 0; done_max <= 0;
      if (!rst_n) begin cyc <= 0; inta_prev <= 0; rd_prev <= 0; ack_prev <= 0; end
    end else begin
      if (mem_rd_o && mem_ack_i && rd_n < 4) begin rd_addr[rd_n] <= mem_addr_o; rd_n <= rd_n + 1; end
      if (inta_o) inta_hi <= inta_hi + 1;
      if (inta_o && !inta_prev) begin
        pulses <= pulses + 1;
        if (pulses == 0) rise1 <= cyc; else rise2 <= cyc;
      end
      if (mem_rd_o && rd_prev && !ack_prev && mem_addr_o != addr_prev) unstable <= unstable + 1;
      if (done_o) begin
        dn <= dn + 1; cap_type <= vec_type_o; cap_ip <= new_ip_o; cap_cs <= new_cs_o;
        done_run <= done_run + 1;
        if (done_run + 1 > done_max) done_max <= done_run + 1;
      end else done_run <= 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1; @(negedge clk); log_clr = 0;
  endtask

  task automatic pulse_boundary();
    @(negedge clk); boundary_i = 1; @(negedge clk); boundary_i = 0; exc_req_i = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (dn == 0 && n < 300) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic check_vector(input logic [7:0] t, input string tag);
    logic [19:0] a = {10'd0, t, 2'b00};
    chk(dn == 1, {tag, " done count"}, dn, 1);
    chk(cap_type == t, {tag, " type"}, cap_type, t);
    chk(rd_n == 2 && rd_addr[0] == a && rd_addr[1] == a + 20'd2, {tag, " R6 read addresses"},
        rd_addr[0], a);
    chk(cap_ip == mem_fn(a) && cap_cs == mem_fn(a + 20'd2), {tag, " R6 ip/cs"}, cap_ip, mem_fn(a));
    chk(done_max == 1 && !busy_o, {tag, " R11 single done then idle"}, done_max, 1);
    chk(unstable == 0, {tag, " R10 stable address"}, unstable, 0);
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o && !inta_o && !mem_rd_o, "R1 control outputs", busy_o, 0);
    chk(vec_type_o == 0 && new_ip_o == 0 && new_cs_o == 0, "R1 data outputs", new_ip_o, 0);
  endtask

  task automatic t_nmi();
    clear_log();
    nmi_i = 1; repeat (3) @(negedge clk);
    pulse_boundary(); wait_done();
    check_vector(8'd2, "R2 nmi");
    chk(pulses == 0, "R2 no acknowledge", pulses, 0);
    clear_log(); pulse_boundary(); repeat (4) @(negedge clk);
    chk(dn == 0 && !busy_o, "R2 held level no retrigger", dn, 0);
    nmi_i = 0; @(negedge clk);
  endtask

  task automatic t_masked();
    clear_log(); intr_i = 1; ie_i = 0;
    pulse_boundary(); repeat (5) @(negedge clk);
    chk(pulses == 0 && dn == 0 && !busy_o, "R4 masked ignored", pulses, 0);
    intr_i = 0;
  endtask

  task automatic t_intr(input logic [7:0] t);
    clear_log(); intr_type = t; intr_i = 1; ie_i = 1;
    pulse_boundary(); wait_done(); intr_i = 0;
    check_vector(t, "R5 intr");
    chk(pulses == 2 && inta_hi == 2, "R5 two one-clock pulses", pulses, 2);
    chk(rise2 - rise1 == GAP + 1, "R5 gap between pulses", rise2 - rise1, GAP + 1);
  endtask

  task automatic t_exc(input logic [7:0] t, input bit others, input string tag);
    clear_log();
    if (others) begin intr_i = 1; ie_i = 1; tf_i = 1; nmi_i = 1; repeat (2) @(negedge clk); end
    exc_req_i = 1; exc_type_i = t;
    pulse_boundary(); wait_done();
    check_vector(t, tag);
    chk(pulses == 0, {tag, " no acknowledge"}, pulses, 0);
    if (others) begin
      // pending nmi beats intr and step next
      clear_log(); pulse_boundary(); wait_done();
      check_vector(8'd2, "R7 nmi over intr");
      // intr beats step next
      clear_log(); intr_type = 8'h55; pulse_boundary(); wait_done();
      check_vector(8'h55, "R7 intr over step");
      nmi_i = 0; intr_i = 0; ie_i = 0; tf_i = 0;
    end
  endtask

  task automatic t_step();
    clear_log(); tf_i = 1;
    pulse_boundary(); wait_done(); tf_i = 0;
    check_vector(8'd1, "R8 single step");
  endtask

  task automatic t_busy_nmi();
    int n = 0;
    clear_log(); intr_type = 8'h30; intr_i = 1; ie_i = 1;
    pulse_boundary();
    while (!mem_rd_o && n < 50) begin @(negedge clk); n++; end
    nmi_i = 1; boundary_i = 1; exc_req_i = 1; exc_type_i = 8'h40;
    @(negedge clk); boundary_i = 0; exc_req_i = 0;
    @(negedge clk); nmi_i = 0;
    wait_done(); intr_i = 0; ie_i = 0;
    check_vector(8'h30, "R12 busy boundary ignored");
    clear_log(); repeat (4) @(negedge clk);
    chk(!busy_o && dn == 0, "R3 waits for boundary", busy_o, 0);
    pulse_boundary(); wait_done();
    check_vector(8'd2, "R3 pending nmi");
  endtask

  bit finished = 0;
  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset();
    t_nmi();
    t_masked();
    t_intr(8'h21);
    t_intr(8'hFF);
    t_exc(8'd3, 1'b1, "R7 R9 breakpoint wins");
    t_exc(8'd0, 1'b0, "R9 divide error");
    t_exc(8'hFF, 1'b0, "R6 top type");
    t_step();
    t_busy_nmi();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule